// File: doc/BRIEF.md
# Power-Management Configuration and Mode-Switch Port

This block holds the configuration registers that place two 64-byte I/O windows, one for power management and one for the SMBus controller, and turns an I/O address into a hit for each window. Software reaches the registers through a 32-bit configuration port. The port is addressed by dword and carries one enable per byte lane, so only the enabled bytes change. A window's decoded base and enable are re-latched one clock after any write that touches that window's base or enable byte.

A separate one-byte command port switches the platform between legacy and ACPI mode. Two reserved command codes set or clear the SCI-enable flag. Every other code raises a one-cycle system-management interrupt, but only while the SMI-generation bit in configuration space is set. A parameter chooses whether the SMM-done marker comes out of reset already set.

Top module: `pmcfg_apm_ctl`

## Requirements
- R1: After reset, the configuration bytes read back as follows. Dword 0x40 reads 0x00000001. Dwords 0x58 and 0x80 read 0x00000000. Dword 0x90 reads {16'h0, SMB_BASE_INIT | 16'h0001}. Dword 0xD0 reads 0x00090000, which is byte 0xD2 = 0x09.
- R2: With SMM_OFF = 1, byte 0x5B resets to 0x02 instead of 0x00, so dword 0x58 reads 0x02000000.
- R3: A configuration write changes only the bytes whose cfg_be bit is set (bit i selects bits 8i+7:8i). Writes to unimplemented offsets have no effect, and those offsets read 0.
- R4: Bit 0 of byte 0x40 always reads 1, whatever value is written to it.
- R5: pm_hit is 1 exactly when io_addr[15:6] equals bits 15:6 of the little-endian value in bytes 0x40–0x43 and bit 0 of byte 0x80 is 1.
- R6: smb_hit is 1 exactly when io_addr[15:6] equals bits 15:6 of bytes 0x90–0x93 and bit 0 of byte 0xD2 is 1. Out of reset this window is enabled at SMB_BASE_INIT.
- R7: The decoded base and enable of a window change on the second rising edge after a write that touches its bytes (0x40–0x43 and 0x80, or 0x90–0x93 and 0xD2). Until then, and when no such write occurs, they hold.
- R8: A command write of 0xF1 sets sci_en and a write of 0xF0 clears it, with effect from the next edge. Neither code produces an SMI.
- R9: Any other command value gives smi = 1 for exactly the one cycle after the write, and only if bit 1 of byte 0x5B (dword 0x58 bit 25) is set. Otherwise it gives no SMI.
- R10: During and after reset, sci_en and smi are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dword | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data, little-endian lanes |
| cfg_rdata | output | 32 | Read data for cfg_dword (combinational) |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the enabled power-management window |
| smb_hit | output | 1 | Address falls in the enabled SMBus window |
| apm_wr | input | 1 | Mode-switch command write strobe |
| apm_data | input | 8 | Command byte |
| sci_en | output | 1 | ACPI mode (SCI enable) flag |
| smi | output | 1 | One-cycle system-management interrupt |

## Verification
The case that is hardest to reach from the ports is the gap between a configuration write and the window decode catching up with it. The bytes already read back the new value, but the hit still reflects the old base or enable for one more edge. The stimulus samples pm_hit at the first falling edge after the enabling write, where it must still be 0, and again one cycle later, where it must be 1. SMI gating depends on a byte that sits in a different dword from the command port. For that reason the command table runs only after that byte has been set through a single-lane write, and a second instance built with SMM_OFF shows the gate opened by reset alone.

// File: rtl/pmcfg_pkg.sv
package pmcfg_pkg;

    localparam int DW_AW   = 6;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int IO_AW   = 16;
    localparam int WIN_LSB = 6;
    localparam int TAG_W   = IO_AW - WIN_LSB;
    localparam int NWIN    = 2;

    // dword indices of the implemented configuration registers
    localparam logic [DW_AW-1:0] DW_PMBASE  = 6'h10; // bytes 0x40-0x43
    localparam logic [DW_AW-1:0] DW_MISC    = 6'h16; // bytes 0x58-0x5B
    localparam logic [DW_AW-1:0] DW_PMEN    = 6'h20; // byte 0x80, lane 0
    localparam logic [DW_AW-1:0] DW_SMBBASE = 6'h24; // bytes 0x90-0x93
    localparam logic [DW_AW-1:0] DW_SMBEN   = 6'h34; // byte 0xD2, lane 2

    localparam int SMI_GATE_BIT = 25;                // byte 0x5B bit 1

    localparam logic [7:0] CMD_ACPI_ON  = 8'hF1;
    localparam logic [7:0] CMD_ACPI_OFF = 8'hF0;

    typedef struct packed {
        logic [DATA_W-1:0] pm_base;
        logic [DATA_W-1:0] misc;
        logic [7:0]        pm_en;
        logic [DATA_W-1:0] smb_base;
        logic [7:0]        smb_en;
        logic              pm_touch;
        logic              smb_touch;
    } cfg_state_t;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int i = 0; i < BE_W; i++) begin
            if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pmcfg_regs.sv
module pmcfg_regs
    import pmcfg_pkg::*;
#(
    parameter bit          SMM_OFF       = 1'b0,
    parameter logic [15:0] SMB_BASE_INIT = 16'h0B00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DW_AW-1:0]  cfg_dword,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [TAG_W-1:0]  pm_tag,
    output logic              pm_en,
    output logic [TAG_W-1:0]  smb_tag,
    output logic              smb_en,
    output logic              pm_touch,
    output logic              smb_touch,
    output logic              smi_gate
);

    localparam cfg_state_t RST = '{
        pm_base:   32'h0000_0001,
        misc:      (SMM_OFF ? 32'h0200_0000 : 32'h0000_0000),
        pm_en:     8'h00,
        smb_base:  {16'h0000, SMB_BASE_INIT | 16'h0001},
        smb_en:    8'h09,
        pm_touch:  1'b0,
        smb_touch: 1'b0
    };

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.pm_touch  = 1'b0;
        st_d.smb_touch = 1'b0;
        if (cfg_wr) begin
            case (cfg_dword)
                DW_PMBASE: begin
                    st_d.pm_base    = lane_merge(st_q.pm_base, cfg_wdata, cfg_be);
                    st_d.pm_base[0] = 1'b1;
                    st_d.pm_touch   = |cfg_be;
                end
                DW_MISC: st_d.misc = lane_merge(st_q.misc, cfg_wdata, cfg_be);
                DW_PMEN: begin
                    if (cfg_be[0]) st_d.pm_en = cfg_wdata[7:0];
                    st_d.pm_touch = cfg_be[0];
                end
                DW_SMBBASE: begin
                    st_d.smb_base  = lane_merge(st_q.smb_base, cfg_wdata, cfg_be);
                    st_d.smb_touch = |cfg_be;
                end
                DW_SMBEN: begin
                    if (cfg_be[2]) st_d.smb_en = cfg_wdata[23:16];
                    st_d.smb_touch = cfg_be[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    always_comb begin
        case (cfg_dword)
            DW_PMBASE:  cfg_rdata = st_q.pm_base;
            DW_MISC:    cfg_rdata = st_q.misc;
            DW_PMEN:    cfg_rdata = {24'h0, st_q.pm_en};
            DW_SMBBASE: cfg_rdata = st_q.smb_base;
            DW_SMBEN:   cfg_rdata = {8'h0, st_q.smb_en, 16'h0};
            default:    cfg_rdata = '0;
        endcase
    end

    assign pm_tag    = st_q.pm_base[IO_AW-1:WIN_LSB];
    assign pm_en     = st_q.pm_en[0];
    assign smb_tag   = st_q.smb_base[IO_AW-1:WIN_LSB];
    assign smb_en    = st_q.smb_en[0];
    assign pm_touch  = st_q.pm_touch;
    assign smb_touch = st_q.smb_touch;
    assign smi_gate  = st_q.misc[SMI_GATE_BIT];

    // R4: the read-only indicator bit never drops
    a_r4_base_lsb_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pm_base[0]);

    // R3: without a write strobe, no stored byte moves
    a_r3_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(st_q.pm_base) && $stable(st_q.misc) &&
                     $stable(st_q.smb_base) && $stable(st_q.pm_en) &&
                     $stable(st_q.smb_en)));

endmodule

// File: rtl/pmcfg_window.sv
module pmcfg_window
    import pmcfg_pkg::*;
#(
    parameter logic [TAG_W-1:0] RST_TAG = '0,
    parameter bit               RST_EN  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [TAG_W-1:0] tag_raw,
    input  logic             en_raw,
    input  logic [TAG_W-1:0] io_tag,
    output logic             hit
);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             en;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (upd) begin
            win_d.tag = tag_raw;
            win_d.en  = en_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '{tag: RST_TAG, en: RST_EN};
        else        win_q <= win_d;
    end

    assign hit = win_q.en && (io_tag == win_q.tag);

    // R7: decode holds unless a relevant write was flagged
    a_r7_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(win_q));

    // R7: a flagged update takes the register values of that cycle
    a_r7_follow_registers: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (win_q.tag == $past(tag_raw) && win_q.en == $past(en_raw)));

endmodule

// File: rtl/pmcfg_apm.sv
module pmcfg_apm
    import pmcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apm_wr,
    input  logic [7:0] apm_data,
    input  logic       smi_gate,
    output logic       sci_en,
    output logic       smi
);

    typedef struct packed {
        logic sci;
        logic smi;
    } apm_t;

    apm_t ap_d, ap_q;

    always_comb begin
        ap_d     = ap_q;
        ap_d.smi = 1'b0;
        if (apm_wr) begin
            if (apm_data == CMD_ACPI_ON)       ap_d.sci = 1'b1;
            else if (apm_data == CMD_ACPI_OFF) ap_d.sci = 1'b0;
            else                               ap_d.smi = smi_gate;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ap_q <= '0;
        else        ap_q <= ap_d;
    end

    assign sci_en = ap_q.sci;
    assign smi    = ap_q.smi;

    a_r8_enable_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == CMD_ACPI_ON) |=> sci_en);

    a_r8_disable_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == CMD_ACPI_OFF) |=> !sci_en);

    a_r8_no_smi_on_mode_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && (apm_data == CMD_ACPI_ON || apm_data == CMD_ACPI_OFF)) |=> !smi);

    a_r9_smi_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> ($past(apm_wr) && $past(smi_gate)));

    a_r9_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_gate |=> !smi);

endmodule

// File: rtl/pmcfg_apm_ctl.sv
module pmcfg_apm_ctl
    import pmcfg_pkg::*;
#(
    parameter bit          SMM_OFF       = 1'b0,
    parameter logic [15:0] SMB_BASE_INIT = 16'h0B00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DW_AW-1:0]  cfg_dword,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [IO_AW-1:0]  io_addr,
    output logic              pm_hit,
    output logic              smb_hit,
    input  logic              apm_wr,
    input  logic [7:0]        apm_data,
    output logic              sci_en,
    output logic              smi
);

    logic [TAG_W-1:0] tag_raw [NWIN];
    logic             en_raw  [NWIN];
    logic             touch   [NWIN];
    logic [NWIN-1:0]  hit_vec;
    logic             smi_gate;

    pmcfg_regs #(
        .SMM_OFF       (SMM_OFF),
        .SMB_BASE_INIT (SMB_BASE_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_dword (cfg_dword),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pm_tag    (tag_raw[0]),
        .pm_en     (en_raw[0]),
        .smb_tag   (tag_raw[1]),
        .smb_en    (en_raw[1]),
        .pm_touch  (touch[0]),
        .smb_touch (touch[1]),
        .smi_gate  (smi_gate)
    );

    // window 0: power management, window 1: SMBus
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [TAG_W-1:0] RTAG = (g == 0) ? '0 : SMB_BASE_INIT[IO_AW-1:WIN_LSB];
        localparam bit               REN  = (g != 0);
        pmcfg_window #(
            .RST_TAG (RTAG),
            .RST_EN  (REN)
        ) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd     (touch[g]),
            .tag_raw (tag_raw[g]),
            .en_raw  (en_raw[g]),
            .io_tag  (io_addr[IO_AW-1:WIN_LSB]),
            .hit     (hit_vec[g])
        );
    end

    assign pm_hit  = hit_vec[0];
    assign smb_hit = hit_vec[1];

    pmcfg_apm u_apm (
        .clk      (clk),
        .rst_n    (rst_n),
        .apm_wr   (apm_wr),
        .apm_data (apm_data),
        .smi_gate (smi_gate),
        .sci_en   (sci_en),
        .smi      (smi)
    );

    // R10: nothing asserted in the first cycle out of reset
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!sci_en && !smi));

endmodule

// File: tb/pmcfg_apm_ctl_tb.sv
module pmcfg_apm_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SMB_INIT = 16'h0B00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dword = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, cfg_rdata_s;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit, pm_hit_s, smb_hit_s;
    logic        apm_wr = 1'b0;
    logic [7:0]  apm_data = '0;
    logic        sci_en, smi, sci_en_s, smi_s;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmcfg_apm_ctl #(.SMM_OFF(1'b0), .SMB_BASE_INIT(SMB_INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dword(cfg_dword),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .pm_hit(pm_hit), .smb_hit(smb_hit),
        .apm_wr(apm_wr), .apm_data(apm_data), .sci_en(sci_en), .smi(smi));

    pmcfg_apm_ctl #(.SMM_OFF(1'b1), .SMB_BASE_INIT(SMB_INIT)) dut_smm_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dword(cfg_dword),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_s),
        .io_addr(io_addr), .pm_hit(pm_hit_s), .smb_hit(smb_hit_s),
        .apm_wr(apm_wr), .apm_data(apm_data), .sci_en(sci_en_s), .smi(smi_s));

    // command vectors: {cmd, expected sci_en, expected smi}, SMI gate open
    localparam int NVEC = 7;
    localparam logic [9:0] APM_VEC [NVEC] = '{
        {8'hF1, 1'b1, 1'b0},
        {8'h33, 1'b1, 1'b1},
        {8'hF0, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b1},
        {8'hF1, 1'b1, 1'b0},
        {8'hFF, 1'b1, 1'b1},
        {8'hF0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] ofs, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_dword = ofs[7:2]; cfg_be = be; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [7:0] ofs, output logic [31:0] d, output logic [31:0] ds);
        cfg_dword = ofs[7:2];
        #1;
        d = cfg_rdata;
        ds = cfg_rdata_s;
    endtask

    task automatic apm_write(input logic [7:0] cmd);
        apm_wr = 1'b1; apm_data = cmd;
        @(posedge clk);
        @(negedge clk);
        apm_wr = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a);
        io_addr = a;
        #1;
    endtask

    initial begin
        logic [31:0] rd, rds;
        repeat (3) @(negedge clk);
        // R10 during reset
        chk("R10 sci_en in reset", {31'h0, sci_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 sci_en", {31'h0, sci_en}, 32'h0);
        chk("R10 smi", {31'h0, smi}, 32'h0);

        // R1 reset values
        cfg_read(8'h40, rd, rds); chk("R1 dword 0x40", rd, 32'h0000_0001);
        cfg_read(8'h58, rd, rds); chk("R1 dword 0x58", rd, 32'h0);
        chk("R2 dword 0x58 with SMM_OFF", rds, 32'h0200_0000);
        cfg_read(8'h80, rd, rds); chk("R1 dword 0x80", rd, 32'h0);
        cfg_read(8'h90, rd, rds); chk("R1 dword 0x90", rd, {16'h0, SMB_INIT | 16'h1});
        cfg_read(8'hD0, rd, rds); chk("R1 dword 0xD0", rd, 32'h0009_0000);

        // R6 reset window, R5 PM window disabled
        probe(16'h0B3F); chk("R6 smb hit at reset base", {31'h0, smb_hit}, 32'h1);
        probe(16'h0B40); chk("R6 smb miss above window", {31'h0, smb_hit}, 32'h0);
        probe(16'h0000); chk("R5 pm disabled at reset", {31'h0, pm_hit}, 32'h0);

        // R3/R4 lane-selective base write
        cfg_write(8'h40, 4'b0011, 32'hFFFF_1280);
        cfg_read(8'h40, rd, rds); chk("R3 partial lanes 0x40", rd, 32'h0000_1281);
        cfg_write(8'h40, 4'b0001, 32'h0000_0000);
        cfg_read(8'h40, rd, rds); chk("R4 bit0 read-only", rd, 32'h0000_1201);
        cfg_write(8'h60, 4'b1111, 32'hDEAD_BEEF);
        cfg_read(8'h60, rd, rds); chk("R3 unmapped offset", rd, 32'h0);

        // R5/R7 enable PM window; decode lags one edge
        probe(16'h1210);
        cfg_write(8'h80, 4'b0001, 32'h0000_0001);
        chk("R7 pm decode not yet updated", {31'h0, pm_hit}, 32'h0);
        @(negedge clk); #1;
        chk("R5 pm hit after enable", {31'h0, pm_hit}, 32'h1);
        probe(16'h1240); chk("R5 pm miss above", {31'h0, pm_hit}, 32'h0);
        probe(16'h11FF); chk("R5 pm miss below", {31'h0, pm_hit}, 32'h0);
        probe(16'h1200);
        cfg_write(8'h80, 4'b0001, 32'h0);
        @(negedge clk); #1;
        chk("R5 pm disabled", {31'h0, pm_hit}, 32'h0);

        // R6 relocate and gate SMBus window
        cfg_write(8'h90, 4'b0011, 32'h0000_C000);
        @(negedge clk);
        probe(16'hC020); chk("R6 smb hit relocated", {31'h0, smb_hit}, 32'h1);
        probe(16'h0B00); chk("R6 smb old base miss", {31'h0, smb_hit}, 32'h0);
        probe(16'hC020);
        cfg_write(8'hD0, 4'b0100, 32'h0);
        @(negedge clk); #1;
        chk("R6 smb disabled", {31'h0, smb_hit}, 32'h0);
        cfg_write(8'hD0, 4'b1011, 32'hFFFF_FFFF);
        @(negedge clk); #1;
        chk("R3 lane 2 masked keeps smb off", {31'h0, smb_hit}, 32'h0);
        cfg_read(8'hD0, rd, rds); chk("R3 dword 0xD0 unchanged", rd, 32'h0);
        cfg_write(8'hD0, 4'b0100, 32'h0001_0000);
        @(negedge clk); probe(16'hC020);
        chk("R6 smb re-enabled", {31'h0, smb_hit}, 32'h1);

        // R9 gate closed on dut_i, open by reset on dut_smm_i
        apm_write(8'h55);
        chk("R9 no smi with gate clear", {31'h0, smi}, 32'h0);
        chk("R2 smi with SMM_OFF gate", {31'h0, smi_s}, 32'h1);
        @(negedge clk);

        // open gate and walk the command table (R8, R9)
        cfg_write(8'h58, 4'b1000, 32'h0200_0000);
        for (int i = 0; i < NVEC; i++) begin
            apm_write(APM_VEC[i][9:2]);
            chk("R8 sci_en after command", {31'h0, sci_en}, {31'h0, APM_VEC[i][1]});
            chk("R9 smi after command", {31'h0, smi}, {31'h0, APM_VEC[i][0]});
            @(negedge clk);
            chk("R9 smi lasts one cycle", {31'h0, smi}, 32'h0);
        end

        cfg_write(8'h58, 4'b1000, 32'h0);
        apm_write(8'h42);
        chk("R9 gate cleared again", {31'h0, smi}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule